// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit is the interrupt front end of one processor core. Up to `LINES` trigger lines set bits in a pending register, and each source learns one cycle later whether its trigger was new or a repeat. The core installs a handler address for every line through a small write port. An entry of zero leaves that line without a handler.

The core pulses an instruction-boundary strobe each time an instruction retires. If interrupts are enabled in the status word, the unit scans the pending bits from index 0 upward. Lines that are pending but have no handler are dropped during that scan, and the first line that has a handler is taken. Entering the handler takes three cycles. The unit pushes the return IP, then pushes the status word, then presents a redirect carrying the handler address and a status word with the enable flag and the four condition flags cleared. A return strobe runs the reverse steps: it pops the status word, pops the IP, and then presents a redirect that restores both.

The stack itself sits outside the unit. It is reached through a one-word push port and a one-word pop port, and each port has its own handshake.

Top module: `irq_dispatch`

## Requirements
- R1: A one-cycle pulse on `trig_i[n]` latches line n as pending. A later enabled boundary dispatches it.
- R2: A trigger on a line that is already pending is ignored, and the matching `dup_o` bit is high in the cycle after the trigger. A first trigger leaves `dup_o` low, and a line triggered twice is dispatched only once.
- R3: A boundary while `stat_i` bit 4 (interrupt enable) is 0 starts no entry and leaves pending lines untouched.
- R4: Among pending lines that have a non-zero handler, the lowest index is dispatched and cleared. Higher-index lines stay pending for later boundaries.
- R5: Pending lines with a zero handler below the chosen line are discarded in the same boundary. If no pending line has a handler, every pending line is discarded and no entry starts.
- R6: Entry order, counted from the boundary edge: cycle 1 pushes the captured IP, cycle 2 pushes the captured status word, cycle 3 raises `redirect_valid_o` with the handler address and the status word with bits 0 to 4 (Z, S, C, O, I) cleared and all other bits kept.
- R7: A pulse on `ret_i` pops the status word first, then the IP. The cycle after the second pop raises `redirect_valid_o` with the popped IP and the popped status word.
- R8: `busy_o` is high from the cycle after a start until its redirect cycle. Boundary and return strobes are ignored while it is high.
- R9: A vector-table write replaces an entry, and writing zero removes that line's handler.
- R10: Reset clears pending lines, removes every handler, and leaves `busy_o`, stack strobes, `redirect_valid_o` and `dup_o` low.
- R11: While `stk_wr_ready_i` is low, the current push is held with the same data and entry does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | LINES | One-cycle trigger pulse per line |
| dup_o | output | LINES | Repeat-trigger indication, one cycle after the trigger |
| boundary_i | input | 1 | Instruction retired; scan allowed |
| ret_i | input | 1 | Return from handler requested |
| ip_i | input | WORD_W | IP to resume at after the handler |
| stat_i | input | WORD_W | Current status word of the core |
| vec_we_i | input | 1 | Vector-table write strobe |
| vec_idx_i | input | IDX_W | Line whose entry is written |
| vec_addr_i | input | WORD_W | Handler address to store (zero = none) |
| busy_o | output | 1 | Entry or return sequence in progress |
| stk_wr_en_o | output | 1 | Push request |
| stk_wr_data_o | output | WORD_W | Word to push |
| stk_wr_ready_i | input | 1 | Stack accepts the push this cycle |
| stk_rd_en_o | output | 1 | Pop request |
| stk_rd_data_i | input | WORD_W | Word on top of the stack |
| stk_rd_valid_i | input | 1 | Pop data is valid this cycle |
| redirect_valid_o | output | 1 | Core must load `redirect_ip_o` and `stat_o` |
| redirect_ip_o | output | WORD_W | New IP |
| stat_o | output | WORD_W | New status word |

## Verification
The bench builds the unit with its defaults: 32 lines, 16-bit words, the enable flag at bit 4 and a clear mask of 0x1F. With 32 lines, both ends of the scan are reachable, lines 0 and 31. Handlers are installed at lines 3, 7, 12 and 31, which leaves lines 0, 1, 2 and 5 with zero handlers, so the zero-handler discard is exercised both below a chosen line and across the whole pending set. The 16-bit status word carries the T and W bits (8 and 9), which lets the bench check that entry keeps them while it clears the low five bits.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_IP,
    S_PUSH_ST,
    S_ENTER,
    S_POP_ST,
    S_POP_IP,
    S_RETURN
  } seq_state_t;

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] trig_i,
  input  logic             clr_en_i,
  input  logic [LINES-1:0] clr_mask_i,
  output logic [LINES-1:0] pend_o,
  output logic [LINES-1:0] dup_o
);

  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] dup_q;
  logic [LINES-1:0] keep_mask;

  assign keep_mask = clr_en_i ? ~clr_mask_i : {LINES{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      dup_q  <= '0;
    end else begin
      // a trigger on a line already pending never re-arms it
      pend_q <= (pend_q & keep_mask) | (trig_i & ~pend_q);
      dup_q  <= trig_i & pend_q;
    end
  end

  assign pend_o = pend_q;
  assign dup_o  = dup_q;

  // R2: a repeat flag only ever follows a line that was pending
  assert_dup_needs_pending_R2: assert property (@(posedge clk) disable iff (rst)
    (dup_q & ~$past(pend_q)) == '0);

  // R4: pending bits only drop in the cycle after a scan
  assert_bits_fall_only_on_scan_R4: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> $past(clr_en_i));

endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int LINES = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_i,
  output logic [LINES-1:0] upto_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o
);

  logic [LINES-1:0] first;

  // isolate lowest set bit; with no request the mask below becomes all ones
  assign first  = req_i & (~req_i + LINES'(1));
  assign upto_o = first | (first - LINES'(1));
  assign hit_o  = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (first[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_vector_table.sv
module irq_vector_table #(
  parameter int LINES  = 32,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [LINES-1:0]  installed_o
);

  logic [WORD_W-1:0] mem_q [LINES];
  logic [WORD_W-1:0] rd_q;
  logic [LINES-1:0]  nz_q;

  // plain synchronous RAM, read with enable, no reset on contents
  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (rd_en_i) rd_q <= mem_q[raddr_i];
  end

  // side mask of non-zero entries so the scan never reads the RAM
  always_ff @(posedge clk) begin
    if (rst) nz_q <= '0;
    else if (we_i) nz_q[waddr_i] <= |wdata_i;
  end

  assign rd_data_o   = rd_q;
  assign installed_o = nz_q;

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IE_BIT = 4,
  parameter logic [WORD_W-1:0] ENTRY_CLEAR = WORD_W'(16'h001F)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic              ret_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] stat_i,
  input  logic              any_pend_i,
  input  logic              hit_i,
  input  logic [WORD_W-1:0] vec_i,
  input  logic              stk_wr_ready_i,
  input  logic              stk_rd_valid_i,
  input  logic [WORD_W-1:0] stk_rd_data_i,
  output logic              scan_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              stk_wr_en_o,
  output logic [WORD_W-1:0] stk_wr_data_o,
  output logic              stk_rd_en_o,
  output logic              redirect_valid_o,
  output logic [WORD_W-1:0] redirect_ip_o,
  output logic [WORD_W-1:0] stat_o
);

  seq_state_t        state_q;
  logic [WORD_W-1:0] ip_q;
  logic [WORD_W-1:0] st_q;
  logic              idle;
  logic              ret_go;

  assign idle    = (state_q == S_IDLE);
  assign ret_go  = idle & ret_i;
  assign scan_o  = idle & boundary_i & ~ret_i & stat_i[IE_BIT] & any_pend_i;
  assign start_o = scan_o & hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ip_q    <= '0;
      st_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (ret_go) begin
            state_q <= S_POP_ST;
          end else if (start_o) begin
            state_q <= S_PUSH_IP;
            ip_q    <= ip_i;
            st_q    <= stat_i;
          end
        end
        S_PUSH_IP: if (stk_wr_ready_i) state_q <= S_PUSH_ST;
        S_PUSH_ST: if (stk_wr_ready_i) state_q <= S_ENTER;
        S_ENTER:   state_q <= S_IDLE;
        S_POP_ST: begin
          if (stk_rd_valid_i) begin
            st_q    <= stk_rd_data_i;
            state_q <= S_POP_IP;
          end
        end
        S_POP_IP: begin
          if (stk_rd_valid_i) begin
            ip_q    <= stk_rd_data_i;
            state_q <= S_RETURN;
          end
        end
        S_RETURN:  state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o           = ~idle;
  assign stk_wr_en_o      = (state_q == S_PUSH_IP) | (state_q == S_PUSH_ST);
  assign stk_wr_data_o    = (state_q == S_PUSH_IP) ? ip_q : st_q;
  assign stk_rd_en_o      = (state_q == S_POP_ST) | (state_q == S_POP_IP);
  assign redirect_valid_o = (state_q == S_ENTER) | (state_q == S_RETURN);
  assign redirect_ip_o    = (state_q == S_ENTER) ? vec_i : ip_q;
  assign stat_o           = (state_q == S_ENTER) ? (st_q & ~ENTRY_CLEAR) : st_q;

  // R3: with interrupts off a boundary leaves the sequencer idle
  assert_no_entry_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (idle && boundary_i && !ret_i && !stat_i[IE_BIT]) |=> (state_q == S_IDLE));

  // R5: a taken handler never jumps to address zero
  assert_target_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ENTER) |-> (vec_i != '0));

  // R6: redirect on entry only after the status push completed
  assert_entry_order_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ENTER) |-> ($past(state_q) == S_PUSH_ST));

  // R7: restore only after the IP pop completed
  assert_return_order_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RETURN) |-> ($past(state_q) == S_POP_IP));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int LINES  = 32,
  parameter int WORD_W = 16,
  parameter int IE_BIT = 4,
  parameter logic [WORD_W-1:0] ENTRY_CLEAR = WORD_W'(16'h001F),
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  trig_i,
  output logic [LINES-1:0]  dup_o,
  input  logic              boundary_i,
  input  logic              ret_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] stat_i,
  input  logic              vec_we_i,
  input  logic [IDX_W-1:0]  vec_idx_i,
  input  logic [WORD_W-1:0] vec_addr_i,
  output logic              busy_o,
  output logic              stk_wr_en_o,
  output logic [WORD_W-1:0] stk_wr_data_o,
  input  logic              stk_wr_ready_i,
  output logic              stk_rd_en_o,
  input  logic [WORD_W-1:0] stk_rd_data_i,
  input  logic              stk_rd_valid_i,
  output logic              redirect_valid_o,
  output logic [WORD_W-1:0] redirect_ip_o,
  output logic [WORD_W-1:0] stat_o
);

  logic [LINES-1:0]  pend;
  logic [LINES-1:0]  installed;
  logic [LINES-1:0]  upto;
  logic [IDX_W-1:0]  sel_idx;
  logic              hit;
  logic              scan;
  logic              start;
  logic [WORD_W-1:0] vec;

  irq_pending #(.LINES(LINES)) u_pending (
    .clk       (clk),
    .rst       (rst),
    .trig_i    (trig_i),
    .clr_en_i  (scan),
    .clr_mask_i(upto),
    .pend_o    (pend),
    .dup_o     (dup_o)
  );

  irq_vector_table #(.LINES(LINES), .WORD_W(WORD_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .we_i       (vec_we_i),
    .waddr_i    (vec_idx_i),
    .wdata_i    (vec_addr_i),
    .rd_en_i    (start),
    .raddr_i    (sel_idx),
    .rd_data_o  (vec),
    .installed_o(installed)
  );

  // zero-handler lines below the first installed one fall inside upto
  irq_lowest #(.LINES(LINES)) u_lowest (
    .req_i (pend & installed),
    .upto_o(upto),
    .idx_o (sel_idx),
    .hit_o (hit)
  );

  irq_seq #(.WORD_W(WORD_W), .IE_BIT(IE_BIT), .ENTRY_CLEAR(ENTRY_CLEAR)) u_seq (
    .clk             (clk),
    .rst             (rst),
    .boundary_i      (boundary_i),
    .ret_i           (ret_i),
    .ip_i            (ip_i),
    .stat_i          (stat_i),
    .any_pend_i      (|pend),
    .hit_i           (hit),
    .vec_i           (vec),
    .stk_wr_ready_i  (stk_wr_ready_i),
    .stk_rd_valid_i  (stk_rd_valid_i),
    .stk_rd_data_i   (stk_rd_data_i),
    .scan_o          (scan),
    .start_o         (start),
    .busy_o          (busy_o),
    .stk_wr_en_o     (stk_wr_en_o),
    .stk_wr_data_o   (stk_wr_data_o),
    .stk_rd_en_o     (stk_rd_en_o),
    .redirect_valid_o(redirect_valid_o),
    .redirect_ip_o   (redirect_ip_o),
    .stat_o          (stat_o)
  );

endmodule

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 32;
  localparam int NROWS = 8;
  localparam logic [31:0] TRIG_TAB [NROWS] = '{
    32'h0000_0008,   // line 3
    32'h0000_1080,   // lines 7,12
    32'h0000_0000,   // drains 12
    32'h0000_0003,   // lines 0,1 (no handler)
    32'h8000_0004,   // lines 2,31
    32'h8000_0028,   // lines 3,5,31
    32'h0000_0000,   // drains 31
    32'h0000_0000    // nothing left
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] trig = '0;
  logic [31:0] dup;
  logic        boundary = 1'b0;
  logic        ret = 1'b0;
  logic [15:0] ip_in = '0;
  logic [15:0] stat_in = '0;
  logic        vec_we = 1'b0;
  logic [4:0]  vec_idx = '0;
  logic [15:0] vec_addr = '0;
  logic        busy;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        wr_ready = 1'b1;
  logic        rd_en;
  logic [15:0] rd_data;
  logic        redir;
  logic [15:0] redir_ip;
  logic [15:0] stat_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mvec [LINES];
  logic [31:0] mpend = '0;
  logic [15:0] smem [16];
  logic [4:0]  sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch i_irq_dispatch (
    .clk(clk), .rst(rst), .trig_i(trig), .dup_o(dup),
    .boundary_i(boundary), .ret_i(ret), .ip_i(ip_in), .stat_i(stat_in),
    .vec_we_i(vec_we), .vec_idx_i(vec_idx), .vec_addr_i(vec_addr),
    .busy_o(busy), .stk_wr_en_o(wr_en), .stk_wr_data_o(wr_data),
    .stk_wr_ready_i(wr_ready), .stk_rd_en_o(rd_en), .stk_rd_data_i(rd_data),
    .stk_rd_valid_i(1'b1), .redirect_valid_o(redir), .redirect_ip_o(redir_ip),
    .stat_o(stat_out)
  );

  // downward stack model, sp points at last pushed word
  always @(posedge clk) begin
    if (rst) sp <= 5'd16;
    else if (wr_en && wr_ready) begin
      smem[4'(sp - 5'd1)] <= wr_data;
      sp <= sp - 5'd1;
    end else if (rd_en) sp <= sp + 5'd1;
  end
  assign rd_data = smem[sp[3:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_vec(input int line, input logic [15:0] a);
    vec_we = 1'b1; vec_idx = 5'(line); vec_addr = a;
    step();
    vec_we = 1'b0;
    mvec[line] = a;
  endtask

  task automatic pulse_trig(input logic [31:0] m);
    trig = m;
    step();
    trig = '0;
    mpend = mpend | m;
  endtask

  function automatic int model_scan();
    for (int i = 0; i < LINES; i++) begin
      if (mpend[i]) begin
        mpend[i] = 1'b0;
        if (mvec[i] != 16'h0) return i;
      end
    end
    return -1;
  endfunction

  // mode 0 plain, 1 push stall, 2 return strobe held while busy
  task automatic do_entry(input logic [15:0] ip, input logic [15:0] st,
                          input int line, input int mode);
    ip_in = ip; stat_in = st; boundary = 1'b1;
    step();
    boundary = 1'b0;
    if (line < 0) begin
      chk("R5 no entry busy", 32'(busy), 32'd0);
      chk("R5 no entry push", 32'(wr_en), 32'd0);
      return;
    end
    chk("R6 cycle1 push IP", {15'd0, wr_en, wr_data}, {15'd0, 1'b1, ip});
    if (mode == 1) begin
      wr_ready = 1'b0;
      for (int k = 0; k < 2; k++) begin
        step();
        chk("R11 push held", {15'd0, wr_en, wr_data}, {15'd0, 1'b1, ip});
      end
      wr_ready = 1'b1;
    end
    if (mode == 2) ret = 1'b1;
    step();
    chk("R6 cycle2 push status", {15'd0, wr_en, wr_data}, {15'd0, 1'b1, st});
    step();
    chk("R6 cycle3 redirect", 32'(redir), 32'd1);
    chk("R4 handler address", 32'(redir_ip), 32'(mvec[line]));
    chk("R6 flags cleared", 32'(stat_out), 32'(st & 16'hFFE0));
    chk("R8 busy in entry", 32'(busy), 32'd1);
    ret = 1'b0;
    step();
    chk("R8 idle after entry", {30'd0, busy, redir}, 32'd0);
  endtask

  task automatic do_return(input logic [15:0] ip, input logic [15:0] st);
    ret = 1'b1;
    step();
    ret = 1'b0;
    chk("R7 pop status", {30'd0, rd_en, wr_en}, 32'd2);
    step();
    chk("R7 pop IP", 32'(rd_en), 32'd1);
    step();
    chk("R7 restore", {15'd0, redir, redir_ip}, {15'd0, 1'b1, ip});
    chk("R7 status restored", 32'(stat_out), 32'(st));
    step();
    chk("R7 idle after return", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) mvec[i] = 16'h0;
    repeat (4) step();
    // R10 reset state
    chk("R10 reset busy", 32'(busy), 32'd0);
    chk("R10 reset strobes", {29'd0, wr_en, rd_en, redir}, 32'd0);
    chk("R10 reset dup", dup, 32'd0);
    rst = 1'b0;
    step();

    // R10 no handlers after reset, R5 everything discarded
    pulse_trig(32'h8);
    do_entry(16'h0100, 16'h0010, model_scan(), 0);

    write_vec(3,  16'h1030);
    write_vec(7,  16'h1070);
    write_vec(12, 16'h10C0);
    write_vec(31, 16'h11F0);

    // R1 R4 R5 R6 R7 table walk
    for (int r = 0; r < NROWS; r++) begin
      int line;
      logic [15:0] rip;
      rip = 16'h2000 + 16'(r);
      if (TRIG_TAB[r] != 0) pulse_trig(TRIG_TAB[r]);
      line = model_scan();
      do_entry(rip, 16'h031F, line, 0);
      if (line >= 0) do_return(rip, 16'h031F);
    end

    // R3 disabled boundary keeps line pending
    pulse_trig(32'h1000);
    do_entry(16'h3000, 16'h000F, -1, 0);
    do_entry(16'h3001, 16'h0010, model_scan(), 0);
    do_return(16'h3001, 16'h0010);

    // R2 duplicate trigger
    pulse_trig(32'h80);
    chk("R2 first trigger not dup", dup, 32'd0);
    pulse_trig(32'h80);
    chk("R2 repeat flagged", dup, 32'h80);
    do_entry(16'h4000, 16'h0311, model_scan(), 0);
    do_return(16'h4000, 16'h0311);
    do_entry(16'h4001, 16'h0311, model_scan(), 0);
    chk("R2 dispatched once", 32'(model_scan()), 32'hFFFF_FFFF);

    // R11 push stall
    pulse_trig(32'h8000_0000);
    do_entry(16'h5000, 16'h001A, model_scan(), 1);
    do_return(16'h5000, 16'h001A);

    // R8 return strobe while busy is ignored
    pulse_trig(32'h8);
    do_entry(16'h6000, 16'h0010, model_scan(), 2);
    chk("R8 stack depth kept", 32'(sp), 32'd14);
    do_return(16'h6000, 16'h0010);

    // R9 overwrite then remove
    write_vec(3, 16'h0ABC);
    pulse_trig(32'h8);
    do_entry(16'h7000, 16'h0010, model_scan(), 0);
    do_return(16'h7000, 16'h0010);
    write_vec(3, 16'h0000);
    pulse_trig(32'h8);
    do_entry(16'h7001, 16'h0010, model_scan(), 0);

    // R10 reset clears pending
    pulse_trig(32'h80);
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    mpend = '0;
    for (int i = 0; i < LINES; i++) mvec[i] = 16'h0;
    step();
    do_entry(16'h8000, 16'h0010, -1, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule